// File: doc/BRIEF.md
# Framed SPI Register Transaction Engine

This block is an SPI master that talks to a network-offload controller over a framed register and buffer interface. Each request from the user side runs one transaction under a single chip-select assertion. The transaction sends a 16-bit address, then a control byte, then a burst of one or more data bytes. The control byte carries a 5-bit block select, the transfer direction and a fixed mode code.

Write payload bytes enter through a valid/ready stream. Read payload bytes leave through a second valid/ready stream. When a stream stalls, the serial clock waits in its low state. If a stall lasts too long, a watchdog abandons the transaction. When chip-select is released, the block pulses either `done` or `error`. The serial clock rate comes from a runtime divider input that is captured with each request. This lets bring-up start slow and speed up later.

Top module: `spi_frame_engine`

## Requirements
- R1: A request accepted while `req_ready` is high drops `cs_n` once and keeps it low until the frame ends. The frame is the address high byte, the address low byte, the control byte and the data bytes, in that order. `cs_n` never rises between payload bytes.
- R2: The control byte is `{req_blk[4:0], dir, 2'b00}`. Here dir is bit 2: 1 for write, 0 for read.
- R3: Serial timing is SPI mode 0. SCLK is low whenever `cs_n` is high. MOSI changes only while SCLK is low. MISO is sampled on the SCLK rising edge. Every byte is shifted MSB first.
- R4: In a write, each data byte is taken from `wr_data` on a `wr_valid`/`wr_ready` handshake, and bytes go out in stream order. `wr_ready` is high only while the block waits for the next byte.
- R5: In a read, each data byte received on MISO appears on `rd_data` with `rd_valid`, in order, and stays until `rd_ready`. MOSI is held at 0 for all read data bytes.
- R6: Each SCLK high phase and each SCLK low phase lasts `div_cfg+1` clock cycles. `div_cfg` is the value captured when the request is accepted.
- R7: A completed transaction pulses `done` for one cycle, in the first cycle in which `cs_n` is high, and does not pulse `error`.
- R8: If the write stream or the read stream stalls for `TMO_CYCLES` cycles inside the data phase, the block raises `cs_n` at once. It then pulses `error` without `done`, drops `rd_valid` and `wr_ready`, and later accepts a new request normally.
- R9: After `cs_n` rises, it stays high for at least two SCLK periods (`4*(div_cfg+1)` cycles) before the next transaction can lower it. `req_ready` stays low during that interval.
- R10: `req_len` is the data byte count minus one. A frame therefore carries `req_len+4` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_cfg | input | DIV_W | SCLK half-period in clock cycles, minus one |
| req_valid | input | 1 | Transaction request valid |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_addr | input | 16 | Register or buffer address |
| req_blk | input | 5 | Block select placed in the control byte |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_len | input | LEN_W | Data byte count minus one |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Engine waiting for a write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Consumer accepts read byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle pulse on normal completion |
| error | output | 1 | One-cycle pulse on watchdog abort |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
The bench uses a bus-level slave model to probe the points where a framed master usually goes wrong:
- **Chip-select between bytes.** A design that re-selects per byte or per phase shows more than one chip-select fall per frame.
- **Byte order and control bits.** A swapped address order or a misplaced direction bit shows as the wrong captured bytes.
- **MISO sampling edge.** Sampling MISO on the wrong edge returns read bytes shifted by a bit.
- **Stream stalls.** Stalls mid-burst must leave the SCLK high phase at exactly the divider width. A watchdog that never fires hangs the frame. One that fires but still pulses `done` would be caught as well.
- **Idle time after release.** A short idle gap after a frame shows up directly in the measured chip-select high time.

// File: rtl/spi_frame_engine.sv
`timescale 1ns/1ps
module spi_frame_engine #(
  parameter int DIV_W      = 8,
  parameter int LEN_W      = 8,
  parameter int TMO_CYCLES = 64,
  parameter int GAP_SCLK   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [15:0]      req_addr,
  input  logic [4:0]       req_blk,
  input  logic             req_wr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             error,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);
  localparam int GAP_HALVES = 2 * GAP_SCLK;
  localparam int WD_W  = $clog2(TMO_CYCLES + 1);
  localparam int GAP_W = $clog2(GAP_HALVES + 1);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_LOAD, S_PUSH, S_GAP} st_t;

  st_t              st;
  logic [DIV_W-1:0] div_q, divcnt;
  logic [7:0]       tsh, rsh, addr_lo, ctl_q;
  logic [2:0]       bitn;
  logic [1:0]       hdr;
  logic             wr_q, sclk_q, cs_q, done_q, err_q;
  logic [LEN_W-1:0] rem;
  logic [WD_W-1:0]  wd;
  logic [GAP_W-1:0] gapn;

  wire run    = (st == S_SHIFT) || (st == S_GAP);
  wire tick   = run && (divcnt == div_q);
  wire last   = (rem == '0);
  wire wd_end = (wd == WD_W'(TMO_CYCLES - 1));

  assign req_ready = (st == S_IDLE);
  assign wr_ready  = (st == S_LOAD);
  assign rd_valid  = (st == S_PUSH);
  assign rd_data   = rsh;
  assign done      = done_q;
  assign error     = err_q;
  assign sclk      = sclk_q;
  assign cs_n      = cs_q;
  assign mosi      = cs_q ? 1'b0 : tsh[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; div_q <= '0; divcnt <= '0; tsh <= '0; rsh <= '0;
      addr_lo <= '0; ctl_q <= '0; bitn <= '0; hdr <= '0; wr_q <= 1'b0;
      sclk_q <= 1'b0; cs_q <= 1'b1; done_q <= 1'b0; err_q <= 1'b0;
      rem <= '0; wd <= '0; gapn <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      divcnt <= (run && !tick) ? divcnt + 1'b1 : '0;
      case (st)
        S_IDLE: if (req_valid) begin
          div_q   <= div_cfg;
          addr_lo <= req_addr[7:0];
          ctl_q   <= {req_blk, req_wr, 2'b00};
          wr_q    <= req_wr;
          rem     <= req_len;
          tsh     <= req_addr[15:8];
          hdr     <= 2'd0;
          bitn    <= 3'd0;
          cs_q    <= 1'b0;
          st      <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rsh    <= {rsh[6:0], miso};
          end else begin
            sclk_q <= 1'b0;
            bitn   <= bitn + 1'b1;
            tsh    <= {tsh[6:0], 1'b0};
            if (bitn == 3'd7) begin
              case (hdr)
                2'd0: begin hdr <= 2'd1; tsh <= addr_lo; end
                2'd1: begin hdr <= 2'd2; tsh <= ctl_q; end
                2'd2: begin
                  hdr <= 2'd3;
                  if (wr_q) st <= S_LOAD;
                end
                default: begin
                  if (!wr_q) st <= S_PUSH;
                  else if (last) begin
                    cs_q <= 1'b1; done_q <= 1'b1; gapn <= '0; st <= S_GAP;
                  end else begin
                    rem <= rem - 1'b1; st <= S_LOAD;
                  end
                end
              endcase
            end
          end
        end
        S_LOAD: begin
          if (wr_valid) begin
            tsh <= wr_data; wd <= '0; st <= S_SHIFT;
          end else if (wd_end) begin
            cs_q <= 1'b1; err_q <= 1'b1; wd <= '0; gapn <= '0; st <= S_GAP;
          end else wd <= wd + 1'b1;
        end
        S_PUSH: begin
          if (rd_ready) begin
            wd <= '0;
            if (last) begin
              cs_q <= 1'b1; done_q <= 1'b1; gapn <= '0; st <= S_GAP;
            end else begin
              rem <= rem - 1'b1; tsh <= '0; st <= S_SHIFT;
            end
          end else if (wd_end) begin
            cs_q <= 1'b1; err_q <= 1'b1; wd <= '0; gapn <= '0; st <= S_GAP;
          end else wd <= wd + 1'b1;
        end
        S_GAP: if (tick) begin
          if (gapn == GAP_W'(GAP_HALVES - 1)) st <= S_IDLE;
          else gapn <= gapn + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  // R7
  flag_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> cs_n);
  // R9
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> (cs_n && !req_ready));
  // R4
  wr_ready_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!cs_n && !sclk));
endmodule

// File: tb/spi_frame_engine_bench.sv
`timescale 1ns/1ps
module spi_frame_engine_bench;
  logic clk = 0, rst_n = 0;
  logic [7:0] div_cfg = 0;
  logic req_valid = 0, req_wr = 0, wr_valid = 0, rd_ready = 0, miso = 0;
  logic [15:0] req_addr = 0;
  logic [4:0] req_blk = 0;
  logic [7:0] req_len = 0, wr_data = 0;
  logic req_ready, wr_ready, rd_valid, done, error, sclk, cs_n, mosi;
  logic [7:0] rd_data;

  spi_frame_engine u_spi_frame_engine (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_blk(req_blk),
    .req_wr(req_wr), .req_len(req_len), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .done(done), .error(error),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int ndone = 0, nerr = 0, csf = 0, nmb = 0, bitc = 0, nrd = 0, viol = 0;
  int sbyte = 0, sbit = 7;
  longint t_rise = 0, t_up = 0, last_gap = 0, hi_min = 0, hi_max = 0;
  logic [7:0] mb [0:31];
  logic [7:0] rd_got [0:15];
  logic [7:0] shreg = 0;
  logic psclk = 0, pmosi = 0, fin = 0;

  function automatic logic [7:0] resp(int k);
    return (k < 3) ? 8'hA5 : 8'(8'h3C + 8'h11 * (k - 3));
  endfunction
  function automatic logic [7:0] wpat(int i);
    return 8'(8'h5A + 8'h13 * i);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (done) ndone++;
    if (error) nerr++;
    if (sclk && psclk && (mosi != pmosi)) viol++;
    psclk = sclk; pmosi = mosi;
  end

  always @(posedge sclk) begin
    shreg = {shreg[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      if (nmb < 32) mb[nmb] = shreg;
      nmb++; bitc = 0;
    end
    t_up = $time;
  end

  always @(negedge sclk) begin
    longint w;
    w = $time - t_up;
    if (w < hi_min) hi_min = w;
    if (w > hi_max) hi_max = w;
    if (sbit == 0) begin sbit = 7; sbyte++; end else sbit--;
    miso = resp(sbyte)[sbit];
  end

  always @(negedge cs_n) begin
    csf++;
    if (t_rise > 0) last_gap = $time - t_rise;
    sbyte = 0; sbit = 7; bitc = 0;
    miso = resp(0)[7];
  end
  always @(posedge cs_n) t_rise = $time;

  task automatic do_txn(input logic [15:0] a, input logic [4:0] b, input bit w,
                        input int n, input int dv, input int wgap, input int rgap,
                        input int wstop, input int rstop);
    int d0, e0;
    d0 = ndone; e0 = nerr;
    nmb = 0; csf = 0; nrd = 0; viol = 0; fin = 0;
    hi_min = 1000000; hi_max = 0;
    div_cfg = 8'(dv);
    fork
      begin
        req_addr = a; req_blk = b; req_wr = w; req_len = 8'(n - 1); req_valid = 1;
        while (!req_ready) @(negedge clk);
        @(negedge clk); req_valid = 0;
      end
      begin
        if (w) begin
          for (int i = 0; i < n && !fin; i++) begin
            if (i == wstop) break;
            repeat (wgap) @(negedge clk);
            wr_valid = 1; wr_data = wpat(i);
            while (!wr_ready && !fin) @(negedge clk);
            @(negedge clk); wr_valid = 0;
          end
        end
      end
      begin
        if (!w) begin
          for (int i = 0; i < n && !fin; i++) begin
            while (!rd_valid && !fin) @(negedge clk);
            if (fin) break;
            if (i == rstop) begin
              while (!fin) @(negedge clk);
              break;
            end
            repeat (rgap) @(negedge clk);
            rd_got[nrd] = rd_data; nrd++;
            rd_ready = 1; @(negedge clk); rd_ready = 0;
          end
        end
      end
      begin
        int c = 0;
        while (ndone == d0 && nerr == e0 && c < 20000) begin
          @(negedge clk); c++;
        end
        fin = 1;
      end
    join
    wr_valid = 0; rd_ready = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(cs_n == 1, "R1 reset cs_n", cs_n, 1);
    chk(sclk == 0, "R3 reset sclk", sclk, 0);
    chk(req_ready == 1, "R9 reset req_ready", req_ready, 1);
    chk(done == 0 && error == 0, "R7 reset flags", {done, error}, 0);
  endtask

  task automatic check_write(input logic [15:0] a, input logic [4:0] b, input int n, input int dv, string nm);
    int d0 = ndone, e0 = nerr;
    do_txn(a, b, 1, n, dv, (n > 2) ? 3 : 0, 0, -1, -1);
    chk(csf == 1, {"R1 one cs frame ", nm}, csf, 1);
    chk(nmb == n + 3, {"R10 byte count ", nm}, nmb, n + 3);
    chk(mb[0] == a[15:8] && mb[1] == a[7:0], {"R1 address ", nm}, {mb[0], mb[1]}, a);
    chk(mb[2] == {b, 1'b1, 2'b00}, {"R2 write ctl ", nm}, mb[2], {b, 1'b1, 2'b00});
    for (int i = 0; i < n; i++)
      chk(mb[3 + i] == wpat(i), {"R4 write data ", nm}, mb[3 + i], wpat(i));
    chk(ndone == d0 + 1 && nerr == e0, {"R7 done only ", nm}, ndone - d0, 1);
    chk(hi_min == (dv + 1) * 10 && hi_max == (dv + 1) * 10, {"R6 high width ", nm}, hi_max, (dv + 1) * 10);
    chk(viol == 0, {"R3 mosi stable ", nm}, viol, 0);
  endtask

  task automatic check_read(input logic [15:0] a, input logic [4:0] b, input int n, input int dv, input int rgap, string nm);
    int d0 = ndone, e0 = nerr;
    do_txn(a, b, 0, n, dv, 0, rgap, -1, -1);
    chk(csf == 1, {"R1 one cs frame ", nm}, csf, 1);
    chk(nmb == n + 3, {"R10 byte count ", nm}, nmb, n + 3);
    chk(mb[2] == {b, 1'b0, 2'b00}, {"R2 read ctl ", nm}, mb[2], {b, 1'b0, 2'b00});
    chk(nrd == n, {"R5 read count ", nm}, nrd, n);
    for (int i = 0; i < n; i++) begin
      chk(rd_got[i] == resp(3 + i), {"R5 R3 read data ", nm}, rd_got[i], resp(3 + i));
      chk(mb[3 + i] == 8'h00, {"R5 mosi zero ", nm}, mb[3 + i], 0);
    end
    chk(ndone == d0 + 1 && nerr == e0, {"R7 done only ", nm}, ndone - d0, 1);
    chk(hi_max == (dv + 1) * 10, {"R6 high width ", nm}, hi_max, (dv + 1) * 10);
  endtask

  task automatic t_write_timeout;
    int d0 = ndone, e0 = nerr;
    do_txn(16'h0440, 5'h05, 1, 3, 0, 0, 0, 1, -1);
    chk(nerr == e0 + 1, "R8 write stall error", nerr - e0, 1);
    chk(ndone == d0, "R8 write stall no done", ndone - d0, 0);
    chk(cs_n == 1 && wr_ready == 0, "R8 cs released", {cs_n, wr_ready}, 2'b10);
    chk(nmb == 4, "R8 bytes before stall", nmb, 4);
    check_write(16'h0A0B, 5'h02, 2, 1, "after wr timeout R8");
  endtask

  task automatic t_read_timeout;
    int d0 = ndone, e0 = nerr;
    do_txn(16'h2200, 5'h11, 0, 2, 1, 0, 0, -1, 0);
    chk(nerr == e0 + 1 && ndone == d0, "R8 read stall error only", nerr - e0, 1);
    chk(rd_valid == 0 && cs_n == 1, "R8 rd_valid dropped", {rd_valid, cs_n}, 2'b01);
    check_read(16'h2201, 5'h11, 1, 0, 0, "after rd timeout R8");
  endtask

  task automatic t_gap;
    check_write(16'h3000, 5'h04, 1, 2, "gap first");
    check_write(16'h3001, 5'h04, 1, 2, "gap second");
    chk(last_gap >= 4 * 3 * 10, "R9 cs high time", last_gap, 120);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    check_write(16'h1234, 5'h0A, 1, 1, "single write");
    check_write(16'hBEEF, 5'h1F, 5, 0, "burst write stalled");
    check_read(16'h0102, 5'h03, 3, 2, 0, "read");
    check_read(16'h8001, 5'h0C, 4, 1, 5, "read backpressure");
    t_write_timeout();
    t_read_timeout();
    t_gap();
    check_write(16'hC0DE, 5'h15, 2, 3, "slow divider R6");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule